// File: doc/BRIEF.md
# Periodic Clock-Pulse Drift Compensator

This block sits on the seconds prescaler of a low-frequency timebase and trims its rate. It counts enable pulses from a slow clock (nominally 32.768 kHz, one fast-clock cycle wide each). It emits a one-cycle seconds tick every 2^PRESC_W slow pulses. At a fixed interval it shortens or stretches one second by a programmed number of slow pulses. The interval is either SHORT_SECS (20 by default) or LONG_SECS (60 by default). Shortening a second adds pulses to the count of the timebase, and stretching it removes them.

Correction is set by one 8-bit register value written through `wr_en`/`wr_data`. Bit 7 picks the interval. Bit 6 picks the direction. Bits [5:0] hold a 6-bit code. A write is held pending and made active at the next interval boundary. `busy` stays high from the write until that boundary, and software writes only while `busy` is low. PRESC_W must be at least 8, so that the largest correction (126 pulses) stays below one second.

Top module: `drift_trim`

## Requirements
- R1: After reset `busy` and `sec_tick` are low, the active setting is zero (no correction, short interval), and every second lasts 2^PRESC_W slow pulses.
- R2: The prescaler advances only in cycles where `slow_tick` is high. `sec_tick` is a one-cycle pulse that ends each second. With no correction, two consecutive ticks are 2^PRESC_W slow pulses apart.
- R3: Bit 7 of the setting selects the interval: 1 gives LONG_SECS seconds and 0 gives SHORT_SECS seconds. The correction is applied only to the last second of each interval.
- R4: With bit 6 clear and code c in 1..63, the last second of each interval is shortened by 2*(c-1) slow pulses. Code 1 therefore gives no change, and code 63 removes 124 pulses.
- R5: With bit 6 set and code c in 1..63, the last second is lengthened by 2*((~c & 6'h3F)+1) slow pulses. Code 6'h3F adds 2 pulses and code 2 adds 124.
- R6: Code 0 gives no correction in either direction, while bit 7 still selects the interval.
- R7: A write while `busy` is low captures `wr_data`, and `busy` is high in the following cycle.
- R8: `busy` stays high until the end of the current interval. It falls in the same cycle as the `sec_tick` that closes that interval, and the new setting governs the interval that starts there.
- R9: A write while `busy` is high is ignored. The pending value is kept, and the setting that becomes active is the one accepted earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock pulse |
| wr_en | input | 1 | Write strobe for the correction setting |
| wr_data | input | 8 | Setting: [7] long interval, [6] subtract, [5:0] code |
| busy | output | 1 | A written setting is waiting for the interval boundary |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |

## Verification
The assertions assume that software follows the handshake, which means every write that matters arrives while `busy` is low. They also assume that `slow_tick` is a clean one-cycle enable and that PRESC_W is large enough that a corrected second never collapses to zero length. The bench runs with a prescaler of 8 bits and intervals of 3 and 5 seconds. It waits for `busy` to drop before each accepted write, and makes writes during `busy` only in the test that targets them. It holds `slow_tick` high except in one run where it alternates, and it measures every second of an interval as a count of cycles between ticks.

// File: rtl/drift_trim.sv
module drift_trim #(
  parameter int PRESC_W    = 15,
  parameter int SHORT_SECS = 20,
  parameter int LONG_SECS  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       busy,
  output logic       sec_tick
);
  localparam int CNT_W = PRESC_W + 1;
  localparam int MAX_SECS = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS;
  localparam int SEC_W = (MAX_SECS < 2) ? 1 : $clog2(MAX_SECS);
  localparam logic [CNT_W-1:0] BASE = CNT_W'((1 << PRESC_W) - 1);

  logic [7:0]       act_q, pend_q;
  logic             busy_q, tick_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] sec_q;

  logic [5:0]       code;
  logic [6:0]       pulses;
  logic [SEC_W-1:0] int_last;
  logic [CNT_W-1:0] limit;
  logic             last_sec, wrap, boundary;

  assign code = act_q[5:0];

  always_comb begin
    if (code == 6'd0)
      pulses = 7'd0;
    else if (act_q[6])
      pulses = 7'(({1'b0, ~code} + 7'd1) << 1);
    else
      pulses = 7'(({1'b0, code} - 7'd1) << 1);
  end

  assign int_last = act_q[7] ? SEC_W'(LONG_SECS - 1) : SEC_W'(SHORT_SECS - 1);
  assign last_sec = (sec_q == int_last);
  assign limit    = !last_sec ? BASE
                  : act_q[6]  ? BASE + CNT_W'(pulses)
                              : BASE - CNT_W'(pulses);
  assign wrap     = slow_tick && (cnt_q == limit);
  assign boundary = wrap && last_sec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 8'd0;
      pend_q <= 8'd0;
      busy_q <= 1'b0;
      tick_q <= 1'b0;
      cnt_q  <= '0;
      sec_q  <= '0;
    end else begin
      tick_q <= wrap;
      if (slow_tick)
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)
        sec_q <= last_sec ? '0 : sec_q + 1'b1;
      if (boundary && busy_q)
        act_q <= pend_q;
      if (wr_en && !busy_q) begin
        pend_q <= wr_data;
        busy_q <= 1'b1;
      end else if (boundary) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign sec_tick = tick_q;
endmodule

module drift_trim_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slow_tick,
  input logic       wr_en,
  input logic       busy,
  input logic       sec_tick,
  input logic [7:0] pend_q,
  input logic [7:0] act_q
);
  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sec_tick);

  // R8
  act_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> sec_tick);

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(pend_q));

  // R2
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(slow_tick));

  // R2
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
endmodule

bind drift_trim drift_trim_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
  .busy(busy), .sec_tick(sec_tick), .pend_q(pend_q), .act_q(act_q)
);

// File: tb/drift_trim_bench.sv
`timescale 1ns/1ps
module drift_trim_bench;
  localparam int W = 8;
  localparam int P = 1 << W;
  localparam int SH = 3;
  localparam int LG = 5;
  localparam int NV = 9;
  localparam logic [7:0] VCFG [NV] = '{8'h05, 8'hBF, 8'h7F, 8'hC2, 8'h00, 8'h81, 8'h40, 8'h50, 8'h9A};
  localparam int VLEN [NV] = '{SH, LG, SH, LG, SH, LG, SH, SH, LG};
  localparam int VDEL [NV] = '{-8, -124, 2, 124, 0, 0, 0, 96, -50};

  logic clk = 0, rst_n = 0, slow_tick = 1, wr_en = 0, gap = 0;
  logic [7:0] wr_data = 0;
  logic busy, sec_tick;
  int checks = 0, errors = 0;
  bit done = 0;

  drift_trim #(.PRESC_W(W), .SHORT_SECS(SH), .LONG_SECS(LG)) u_drift_trim (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_data(wr_data), .busy(busy), .sec_tick(sec_tick));

  always #2 clk = ~clk;

  always @(negedge clk) slow_tick <= gap ? ~slow_tick : 1'b1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int len);
    len = 0;
    do begin @(negedge clk); len++; end while (!sec_tick);
  endtask

  task automatic sync_tick();
    do @(negedge clk); while (!sec_tick);
  endtask

  task automatic write_cfg(input logic [7:0] d);
    wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_boundary();
    while (busy) @(negedge clk);
    check("R8 tick at busy fall", sec_tick, 1);
  endtask

  task automatic check_interval(input string req, input int ilen, input int del);
    int len;
    for (int k = 0; k < ilen; k++) begin
      measure(len);
      check(req, len, (k == ilen - 1) ? P + del : P);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 sec_tick after reset", sec_tick, 0);
    sync_tick();
    // R1 / R2: uncorrected seconds
    for (int k = 0; k < 4; k++) begin
      measure(len);
      check("R1 R2 base second", len, P);
    end
    // R2: prescaler waits on slow_tick
    gap = 1;
    sync_tick();
    measure(len);
    check("R2 gated prescaler", len, 2 * P);
    measure(len);
    check("R2 gated prescaler", len, 2 * P);
    gap = 0;
    sync_tick();

    // R3 R4 R5 R6 R7 R8: vector walk
    for (int i = 0; i < NV; i++) begin
      write_cfg(VCFG[i]);
      check("R7 busy after write", busy, 1);
      wait_boundary();
      check_interval(VDEL[i] < 0 ? "R3 R4 add" : (VDEL[i] > 0 ? "R3 R5 sub" : "R3 R6 none"),
                     VLEN[i], VDEL[i]);
    end

    // R9: write during busy is ignored
    write_cfg(8'h45 ^ 8'h40);
    check("R7 busy after write", busy, 1);
    @(negedge clk);
    write_cfg(8'hC2);
    check("R9 busy kept", busy, 1);
    wait_boundary();
    check_interval("R9 ignored write", SH, -8);
    check("R9 busy after boundary", busy, 0);
    check_interval("R9 ignored write later", SH, -8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule